// File: doc/BRIEF.md
# IN Endpoint Abort Sequencer

This block models a transmit (device-to-host) endpoint with a small ring of packet banks and adds a sequencer that empties it safely. Software-side logic streams words into the current fill bank and commits it as a packet; the host side pulls committed packets out oldest first with a start strobe and a valid/ready output stream. A busy count tracks how many committed packets still wait for the host. A transmit-ready status (a free bank exists) is gated by an interrupt enable to form the interrupt line.

The abort sequencer empties the endpoint without racing the host. It masks the transmit-ready interrupt first. It then discards queued packets one at a time, always the most recently committed one, and waits for each discard to finish before it looks at the busy count again. Once the count is zero it pulses the endpoint reset and reports completion. The same kill, reset and interrupt-enable controls are also available as direct set/clear inputs.

Both streams follow valid/ready rules. A word moves on a rising edge only when valid and ready are both high. The write side may hold `wr_valid` while `wr_ready` is low. The output stream keeps `tx_valid` and `tx_data` steady until `tx_ready` takes the word.

Top module: `ep_in_abort`

## Requirements
- R1: `wr_ready` is high exactly when fewer than NBANK packets are queued, no kill is pending and the fill bank holds fewer than DEPTH words. An accepted word is appended to the fill bank.
- R2: `wr_commit` queues the fill bank as a packet and raises `busy_cnt` by one. A word accepted in the same cycle is part of that packet. A commit with no words, during a pending kill, or with all banks queued changes nothing. `busy_cnt` never exceeds NBANK.
- R3: `rd_start`, taken when a packet is queued, no drain is running and no kill is pending, streams the oldest queued packet in write order. `tx_last` marks its final word. Once that word is accepted, `busy_cnt` drops by one. While stalled, the output holds its word.
- R4: `txrdy_st` is high while `busy_cnt` < NBANK. `irq` is `txrdy_st` AND the enable bit. The enable resets to 0, is set by `ie_set` and cleared by `ie_clr`, and clear wins.
- R5: `kill_set`, taken while a packet is queued and no kill is pending, raises `kill_st` on the next cycle. `kill_st` stays high for exactly two cycles.
- R6: A kill removes the newest queued packet and discards any partly written words. `busy_cnt` drops in the same cycle that `kill_st` falls. The older packets remain readable in order.
- R7: A kill whose target packet is being drained is dropped. `busy_cnt` is not lowered by it, the drain delivers every word, and `kill_st` still falls on time.
- R8: `eprst_set` returns the endpoint to idle in one cycle: `busy_cnt` 0, no drain, no pending kill, empty fill bank, `txrdy_st` 1.
- R9: `abort_start` masks the interrupt enable in the first step, before any kill. `ie_set` is ignored while `abort_active` is high.
- R10: The abort kills one packet at a time until `busy_cnt` is 0. It then applies the endpoint reset, and `abort_done` pulses for one cycle with `busy_cnt` 0. With nothing queued it goes straight to the reset, and `abort_done` is high on the third cycle after the start strobe.
- R11: `abort_start` is ignored while an abort is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_valid | input | 1 | write word valid |
| wr_ready | output | 1 | write word can be taken |
| wr_data | input | DATA_W | write word |
| wr_commit | input | 1 | queue the fill bank as a packet |
| rd_start | input | 1 | host begins draining the oldest packet |
| tx_valid | output | 1 | output word valid |
| tx_ready | input | 1 | output word taken |
| tx_data | output | DATA_W | output word |
| tx_last | output | 1 | final word of the packet |
| ie_set | input | 1 | set interrupt enable |
| ie_clr | input | 1 | clear interrupt enable |
| kill_set | input | 1 | request a kill of the newest packet |
| eprst_set | input | 1 | endpoint reset |
| txrdy_st | output | 1 | a free bank exists |
| irq | output | 1 | transmit-ready interrupt |
| kill_st | output | 1 | kill in progress |
| busy_cnt | output | $clog2(NBANK+1) | queued packet count |
| abort_start | input | 1 | begin abort |
| abort_active | output | 1 | abort running |
| abort_done | output | 1 | one-cycle abort completion |

## Verification
The bench builds the block with NBANK=3, DEPTH=4 and DATA_W=8. With three banks the abort loop runs three kill rounds, and newest-first removal shows up as distinct packets surviving in order. With four-word banks a full bank and a full ring both become reachable, so write back-pressure and a masked transmit-ready can be observed. A one-bank drain with the output stalled lets a kill hit the packet being read.

// File: rtl/ep_abort_pkg.sv
`timescale 1ns/1ps
package ep_abort_pkg;
  typedef enum logic [2:0] {
    AB_IDLE  = 3'd0,
    AB_MASK  = 3'd1,
    AB_CHECK = 3'd2,
    AB_WAIT  = 3'd3,
    AB_DONE  = 3'd4
  } abort_state_e;
endpackage

// File: rtl/ep_bank_store.sv
`timescale 1ns/1ps
module ep_bank_store #(
  parameter int NBANK  = 3,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(NBANK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_commit,
  input  logic              rd_start,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  input  logic              kill_pend,
  input  logic              kill_fire,
  input  logic              eprst,
  output logic [CNT_W-1:0]  busy_cnt
);
  localparam int PTR_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LEN_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PLAST = PTR_W'(NBANK - 1);
  localparam logic [CNT_W-1:0] CFULL = CNT_W'(NBANK);
  localparam logic [LEN_W-1:0] LFULL = LEN_W'(DEPTH);

  logic [DATA_W-1:0] mem [NBANK][DEPTH];
  logic [LEN_W-1:0]  len [NBANK];
  logic [PTR_W-1:0]  wptr, rptr, wnext, rnext, tgt;
  logic [LEN_W-1:0]  fill;
  logic [IDX_W-1:0]  ridx;
  logic [CNT_W-1:0]  busy, busy_n;
  logic              drn, space, beat, commit_ok, kill_rm, rd_go, rd_done;

  assign wnext = (wptr == PLAST) ? '0 : wptr + 1'b1;
  assign rnext = (rptr == PLAST) ? '0 : rptr + 1'b1;
  assign tgt   = (wptr == '0) ? PLAST : wptr - 1'b1;

  assign space     = (busy != CFULL);
  assign wr_ready  = space && !kill_pend && (fill != LFULL);
  assign beat      = wr_valid && wr_ready;
  assign commit_ok = wr_commit && space && !kill_pend && ((fill != '0) || beat);
  assign kill_rm   = kill_fire && (busy != '0) && !(drn && (rptr == tgt));
  assign rd_go     = rd_start && !drn && (busy != '0) && !kill_pend;

  assign tx_valid = drn;
  assign tx_data  = mem[rptr][ridx];
  assign tx_last  = ((LEN_W'(ridx) + LEN_W'(1)) == len[rptr]);
  assign rd_done  = drn && tx_ready && tx_last;
  assign busy_cnt = busy;

  always_comb begin
    busy_n = busy;
    if (commit_ok) busy_n = busy_n + 1'b1;
    if (rd_done)   busy_n = busy_n - 1'b1;
    if (kill_rm)   busy_n = busy_n - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (beat && !eprst) mem[wptr][fill[IDX_W-1:0]] <= wr_data;
    if (commit_ok && !eprst) len[wptr] <= fill + LEN_W'(beat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; fill <= '0; busy <= '0; drn <= 1'b0; ridx <= '0;
    end else if (eprst) begin
      wptr <= '0; rptr <= '0; fill <= '0; busy <= '0; drn <= 1'b0; ridx <= '0;
    end else begin
      if (commit_ok) begin
        wptr <= wnext;
        fill <= '0;
      end else if (kill_rm) begin
        wptr <= tgt;
        fill <= '0;
      end else if (beat) begin
        fill <= fill + 1'b1;
      end
      if (rd_go) begin
        drn  <= 1'b1;
        ridx <= '0;
      end else if (drn && tx_ready) begin
        if (tx_last) begin
          drn  <= 1'b0;
          rptr <= rnext;
        end else begin
          ridx <= ridx + 1'b1;
        end
      end
      busy <= busy_n;
    end
  end

  AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n) busy <= CFULL); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !eprst) |=> (tx_valid && $stable(tx_data))); // R3
  AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eprst |=> (busy == '0 && !drn && fill == '0)); // R8
  AST_KILL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_fire && !drn && busy != '0 && !eprst) |=> (busy == $past(busy) - 1'b1)); // R6
  AST_KILL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_fire && drn && busy == CNT_W'(1) && !(tx_ready && tx_last) && !eprst)
      |=> (busy == CNT_W'(1) && drn)); // R7
endmodule

// File: rtl/ep_kill_timer.sv
`timescale 1ns/1ps
module ep_kill_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic kill_req,
  input  logic busy_nz,
  input  logic eprst,
  output logic kill_st,
  output logic kill_fire
);
  logic age;

  assign kill_fire = kill_st && age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kill_st <= 1'b0; age <= 1'b0;
    end else if (eprst || kill_fire) begin
      kill_st <= 1'b0; age <= 1'b0;
    end else if (kill_st) begin
      age <= 1'b1;
    end else if (kill_req && busy_nz) begin
      kill_st <= 1'b1; age <= 1'b0;
    end
  end

  AST_KILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(kill_st) && !eprst) |=> kill_st); // R5
  AST_KILL_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kill_st) |-> ##2 !kill_st); // R5
endmodule

// File: rtl/ep_abort_seq.sv
`timescale 1ns/1ps
module ep_abort_seq
  import ep_abort_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy_nz,
  input  logic kill_st,
  input  logic ie,
  output logic ie_clr_req,
  output logic kill_req,
  output logic eprst_req,
  output logic active,
  output logic done
);
  abort_state_e st, nxt;

  always_comb begin
    nxt = st;
    ie_clr_req = 1'b0;
    kill_req   = 1'b0;
    eprst_req  = 1'b0;
    case (st)
      AB_IDLE:  if (start) nxt = AB_MASK;
      AB_MASK: begin
        ie_clr_req = 1'b1;
        nxt = AB_CHECK;
      end
      AB_CHECK: begin
        if (busy_nz) begin
          kill_req = 1'b1;
          nxt = AB_WAIT;
        end else begin
          eprst_req = 1'b1;
          nxt = AB_DONE;
        end
      end
      AB_WAIT:  if (!kill_st) nxt = AB_CHECK;
      AB_DONE:  nxt = AB_IDLE;
      default:  nxt = AB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= AB_IDLE;
    else        st <= nxt;
  end

  assign active = (st != AB_IDLE);
  assign done   = (st == AB_DONE);

  AST_MASK_FIRST: assert property (@(posedge clk) disable iff (!rst_n) kill_req |-> !ie); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == AB_IDLE && start) |=> (st == AB_MASK)); // R9
endmodule

// File: rtl/ep_in_abort.sv
`timescale 1ns/1ps
module ep_in_abort #(
  parameter int NBANK  = 3,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(NBANK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_commit,
  input  logic              rd_start,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              kill_set,
  input  logic              eprst_set,
  output logic              txrdy_st,
  output logic              irq,
  output logic              kill_st,
  output logic [CNT_W-1:0]  busy_cnt,
  input  logic              abort_start,
  output logic              abort_active,
  output logic              abort_done
);
  localparam logic [CNT_W-1:0] CFULL = CNT_W'(NBANK);

  logic ie, kill_fire, seq_ie_clr, seq_kill, seq_eprst;
  logic kill_any, eprst_any, busy_nz;

  assign kill_any  = kill_set | seq_kill;
  assign eprst_any = eprst_set | seq_eprst;
  assign busy_nz   = (busy_cnt != '0);
  assign txrdy_st  = (busy_cnt != CFULL);
  assign irq       = ie && txrdy_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ie <= 1'b0;
    else if (ie_clr || seq_ie_clr)       ie <= 1'b0;
    else if (ie_set && !abort_active)    ie <= 1'b1;
  end

  ep_bank_store #(.NBANK(NBANK), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_commit(wr_commit),
    .rd_start(rd_start), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last),
    .kill_pend(kill_st), .kill_fire(kill_fire), .eprst(eprst_any),
    .busy_cnt(busy_cnt)
  );

  ep_kill_timer u_kill (
    .clk(clk), .rst_n(rst_n), .kill_req(kill_any), .busy_nz(busy_nz),
    .eprst(eprst_any), .kill_st(kill_st), .kill_fire(kill_fire)
  );

  ep_abort_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(abort_start), .busy_nz(busy_nz),
    .kill_st(kill_st), .ie(ie), .ie_clr_req(seq_ie_clr), .kill_req(seq_kill),
    .eprst_req(seq_eprst), .active(abort_active), .done(abort_done)
  );

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |-> (busy_cnt == '0 && !kill_st)); // R10
  AST_NO_IE_IN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_active && !abort_done && $past(abort_active)) |-> !ie); // R9
endmodule

// File: tb/sim_ep_in_abort.sv
`timescale 1ns/1ps
module sim_ep_in_abort;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, wr_commit = 0, rd_start = 0, tx_ready = 0;
  logic ie_set = 0, ie_clr = 0, kill_set = 0, eprst_set = 0, abort_start = 0;
  logic [7:0] wr_data = '0;
  logic wr_ready, tx_valid, tx_last, txrdy_st, irq, kill_st, abort_active, abort_done;
  logic [7:0] tx_data;
  logic [1:0] busy_cnt;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ep_in_abort #(.NBANK(3), .DEPTH(4), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_commit(wr_commit), .rd_start(rd_start), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .ie_set(ie_set), .ie_clr(ie_clr),
    .kill_set(kill_set), .eprst_set(eprst_set), .txrdy_st(txrdy_st), .irq(irq),
    .kill_st(kill_st), .busy_cnt(busy_cnt), .abort_start(abort_start),
    .abort_active(abort_active), .abort_done(abort_done)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wr_pkt(input int n, input logic [31:0] w);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_data = w[8*i +: 8]; wr_commit = (i == n - 1);
      chk("R1", "wr_ready during write", int'(wr_ready), 1);
      tick();
    end
    wr_valid = 0; wr_commit = 0;
  endtask

  task automatic rd_pkt(input int n, input logic [31:0] w, input string tag);
    rd_start = 1; tick(); rd_start = 0; tx_ready = 1;
    for (int i = 0; i < n; i++) begin
      chk(tag, "tx_valid", int'(tx_valid), 1);
      chk(tag, "tx_data", int'(tx_data), int'(w[8*i +: 8]));
      chk(tag, "tx_last", int'(tx_last), int'(i == n - 1));
      tick();
    end
    tx_ready = 0;
  endtask

  task automatic t_reset();
    chk("R8", "busy after reset", int'(busy_cnt), 0);
    chk("R1", "wr_ready after reset", int'(wr_ready), 1);
    chk("R4", "txrdy after reset", int'(txrdy_st), 1);
    chk("R4", "irq after reset", int'(irq), 0);
    chk("R5", "kill_st after reset", int'(kill_st), 0);
    chk("R10", "abort_done after reset", int'(abort_done), 0);
  endtask

  task automatic t_stream();
    wr_pkt(3, 32'h00_A3_A2_A1);
    chk("R2", "busy after one commit", int'(busy_cnt), 1);
    wr_pkt(2, 32'h00_00_B2_B1);
    chk("R2", "busy after two commits", int'(busy_cnt), 2);
    rd_pkt(3, 32'h00_A3_A2_A1, "R3");
    chk("R3", "busy after first drain", int'(busy_cnt), 1);
    rd_pkt(2, 32'h00_00_B2_B1, "R3");
    chk("R3", "busy after second drain", int'(busy_cnt), 0);
    chk("R3", "tx_valid idle", int'(tx_valid), 0);
  endtask

  task automatic t_full_and_reset();
    wr_commit = 1; tick(); wr_commit = 0;
    chk("R2", "empty commit ignored", int'(busy_cnt), 0);
    wr_pkt(4, 32'h14_13_12_11);
    wr_pkt(1, 32'h21);
    wr_pkt(1, 32'h31);
    chk("R2", "busy at full ring", int'(busy_cnt), 3);
    chk("R1", "wr_ready low when full", int'(wr_ready), 0);
    chk("R4", "txrdy low when full", int'(txrdy_st), 0);
    wr_commit = 1; wr_valid = 1; wr_data = 8'h99; tick(); wr_commit = 0; wr_valid = 0;
    chk("R2", "commit at full ignored", int'(busy_cnt), 3);
    eprst_set = 1; tick(); eprst_set = 0;
    chk("R8", "busy after eprst", int'(busy_cnt), 0);
    chk("R8", "txrdy after eprst", int'(txrdy_st), 1);
    chk("R8", "tx_valid after eprst", int'(tx_valid), 0);
    wr_valid = 1; wr_data = 8'h77; tick(); wr_valid = 0;
    eprst_set = 1; tick(); eprst_set = 0;
    wr_pkt(1, 32'h55);
    rd_pkt(1, 32'h55, "R8");
    chk("R8", "fill bank cleared by eprst", int'(busy_cnt), 0);
  endtask

  task automatic t_irq();
    ie_set = 1; tick(); ie_set = 0;
    chk("R4", "irq after ie_set", int'(irq), 1);
    ie_set = 1; ie_clr = 1; tick(); ie_set = 0; ie_clr = 0;
    chk("R4", "clear wins", int'(irq), 0);
    ie_set = 1; tick(); ie_set = 0;
    chk("R4", "irq set again", int'(irq), 1);
  endtask

  task automatic t_kill_newest();
    wr_pkt(2, 32'h11_10);
    wr_pkt(1, 32'h20);
    wr_pkt(3, 32'h32_31_30);
    kill_set = 1; tick(); kill_set = 0;
    chk("R5", "kill_st first cycle", int'(kill_st), 1);
    tick();
    chk("R5", "kill_st second cycle", int'(kill_st), 1);
    chk("R6", "busy before kill end", int'(busy_cnt), 3);
    tick();
    chk("R5", "kill_st cleared", int'(kill_st), 0);
    chk("R6", "busy drops with kill_st", int'(busy_cnt), 2);
    rd_pkt(2, 32'h11_10, "R6");
    rd_pkt(1, 32'h20, "R6");
    chk("R6", "busy after remaining drains", int'(busy_cnt), 0);
    wr_pkt(1, 32'h40);
    rd_pkt(1, 32'h40, "R6");
  endtask

  task automatic t_kill_drop();
    wr_pkt(2, 32'h62_61);
    rd_start = 1; tick(); rd_start = 0;
    kill_set = 1; tick(); kill_set = 0;
    chk("R7", "kill_st raised", int'(kill_st), 1);
    tick(); tick();
    chk("R7", "kill_st falls on time", int'(kill_st), 0);
    chk("R7", "busy kept", int'(busy_cnt), 1);
    tx_ready = 1;
    for (int i = 0; i < 2; i++) begin
      chk("R7", "drain word", int'(tx_data), (i == 0) ? 8'h61 : 8'h62);
      chk("R7", "drain valid", int'(tx_valid), 1);
      tick();
    end
    tx_ready = 0;
    chk("R7", "busy after drain", int'(busy_cnt), 0);
  endtask

  task automatic t_abort();
    int kills = 0, dones = 0;
    bit prev_k = 0, ie_seen = 0;
    ie_set = 1; tick(); ie_set = 0;
    wr_pkt(1, 32'h71); wr_pkt(1, 32'h72); wr_pkt(1, 32'h73);
    abort_start = 1; tick(); abort_start = 0;
    chk("R9", "abort_active", int'(abort_active), 1);
    for (int c = 0; c < 60; c++) begin
      if (c == 3) begin ie_set = 1; abort_start = 1; end
      if (c == 4) begin ie_set = 0; abort_start = 0; end
      if (kill_st && !prev_k) begin
        kills++;
        if (irq) ie_seen = 1;
      end
      prev_k = kill_st;
      if (abort_done) begin
        dones++;
        chk("R10", "busy at done", int'(busy_cnt), 0);
      end
      tick();
    end
    chk("R10", "kill rounds", kills, 3);
    chk("R11", "single done pulse", dones, 1);
    chk("R9", "irq masked during kills", int'(ie_seen), 0);
    chk("R9", "irq still masked after abort", int'(irq), 0);
    chk("R10", "txrdy after abort", int'(txrdy_st), 1);
  endtask

  task automatic t_abort_empty();
    abort_start = 1; tick(); abort_start = 0;
    chk("R10", "no done cycle 1", int'(abort_done), 0);
    tick();
    chk("R10", "no done cycle 2", int'(abort_done), 0);
    tick();
    chk("R10", "done on cycle 3", int'(abort_done), 1);
    chk("R10", "no kill when empty", int'(kill_st), 0);
    tick();
    chk("R10", "done is one cycle", int'(abort_done), 0);
    chk("R10", "idle after done", int'(abort_active), 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_stream();
    t_full_and_reset();
    t_irq();
    t_kill_newest();
    t_kill_drop();
    t_abort();
    t_abort_empty();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule